// File: doc/BRIEF.md
# Quasi-Bidirectional GPIO Port Controller

This block controls two ports of eight general-purpose I/O lines each, with no direction register. Every line is set by two register bits: an output-level bit and an active-low pull-up bit. A zero in the level bit drives the pad low. A one in the level bit, together with a zero in the pull-up bit, holds the pad high through the internal resistor. A one in both bits leaves the pad floating. The pad cell gets three per-line controls that decode these cases, plus a sink-current enable that the suspend input forces off.

Firmware reaches the registers over a small I/O bus made of an address, a write strobe with write data, and a read strobe with read data. A read of a level address does not return what was written. It returns the pin levels after they pass through a two-flop synchronizer, so software always sees the real line state. Each line also has an interrupt-enable bit. A falling edge on an enabled line produces a one-cycle request on the output of that line's port.

Top module: `qbio_port_ctrl`

## Requirements
- R1: After reset, every level bit is 1, every pull-up bit is 0 and every interrupt-enable bit is 0. As a result, every line reports pull-up, no line is driven low or floating, and no interrupt request is raised.
- R2: When a line's level bit is 0, pad_drive_low is 1 and pad_pull_en and pad_hiz are 0, whatever its pull-up bit holds.
- R3: When a line's level bit is 1 and its pull-up bit is 0, pad_pull_en is 1 and pad_drive_low and pad_hiz are 0.
- R4: When a line's level bit and pull-up bit are both 1, pad_hiz is 1 and pad_drive_low and pad_pull_en are 0.
- R5: Address map: 0x00 and 0x01 hold the level registers of port 0 and port 1, 0x04 and 0x05 hold their pull-up registers, and 0x06 and 0x07 hold their interrupt-enable registers. Bit i of a port register controls line i of that port, which is pin index i for port 0 and 8+i for port 1. A write takes effect on the clock edge where io_wr is sampled high.
- R6: While io_rd is high, a read of 0x00 or 0x01 returns that port's pin inputs after a two-stage synchronizer. A pin change applied before clock edge k is visible after edge k+1 and not after edge k alone. The level register contents are never returned.
- R7: While io_rd is high, a read of 0x04 to 0x07 returns the register contents. io_rdata is 0x00 whenever io_rd is low.
- R8: A write to any address outside 0x00, 0x01 and 0x04 to 0x07 changes no register and no output. A read of such an address returns 0x00.
- R9: A falling edge on a line whose interrupt-enable bit is 1 raises irq_req for that port (bit 0 for port 0, bit 1 for port 1) for exactly one cycle. If the pin falls before edge k, the request is high from edge k+2 to edge k+3. Rising edges and edges on disabled lines raise no request.
- R10: pad_sink_en equals pad_drive_low while suspend is 0 and is all zeros while suspend is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | I/O register address |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, combinational |
| pin_in | input | 16 | Pad input levels, asynchronous |
| suspend | input | 1 | Suspend state from the status and control register |
| pad_drive_low | output | 16 | Per-line active pull-down |
| pad_pull_en | output | 16 | Per-line internal pull-up enable |
| pad_hiz | output | 16 | Per-line high-impedance indication |
| pad_sink_en | output | 16 | Per-line sink-current enable, gated by suspend |
| irq_req | output | 2 | Per-port falling-edge interrupt pulse |

## Verification
The bench sets a level bit to 0 while the matching pull-up bit is 1. A design that lets the pull-up bit win in that case would show the line floating instead of driven low. Reads of a level address are placed where the pin input and the written level disagree, and are sampled one edge and then two edges after a pin change. A design that returns the register, or that uses one or three synchronizer stages, gives the wrong byte at one of those samples. Unmapped writes go to 0x02, 0x03 and 0x08, because a design with a partial address decode would alias them onto real registers. The interrupt tests apply rising edges, falls on disabled lines and a fall on port 1. Each is checked so that a level-sensitive or stretched request, or a request on the wrong port, shows up as a mismatch.

// File: rtl/qbio_pkg.sv
package qbio_pkg;
    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_LVL  = 2'd1,
        REG_PULL = 2'd2,
        REG_IEN  = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/qbio_sync.sv
module qbio_sync #(
    parameter int          WIDTH   = 16,
    parameter int          STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {(STAGES*WIDTH){RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/qbio_regfile.sv
module qbio_regfile
    import qbio_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int PORT_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int LVL_BASE  = 0,
    parameter int PULL_BASE = 4,
    parameter int IEN_BASE  = 6,
    localparam int NLINES   = NUM_PORTS * PORT_W,
    localparam int PSEL_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [PORT_W-1:0] wdata,
    input  logic              rd,
    output logic [PORT_W-1:0] rdata,
    input  logic [NLINES-1:0] pin_sync,
    output logic [NLINES-1:0] lvl,
    output logic [NLINES-1:0] pull_n,
    output logic [NLINES-1:0] ien
);
    typedef struct packed {
        logic [NLINES-1:0] lvl;
        logic [NLINES-1:0] pull_n;
        logic [NLINES-1:0] ien;
    } regs_t;

    regs_t       regs_d, regs_q;
    reg_kind_e   kind;
    logic [PSEL_W-1:0] psel;

    always_comb begin
        kind = REG_NONE;
        psel = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (addr == ADDR_W'(LVL_BASE + p)) begin
                kind = REG_LVL;  psel = PSEL_W'(p);
            end
            if (addr == ADDR_W'(PULL_BASE + p)) begin
                kind = REG_PULL; psel = PSEL_W'(p);
            end
            if (addr == ADDR_W'(IEN_BASE + p)) begin
                kind = REG_IEN;  psel = PSEL_W'(p);
            end
        end
    end

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            unique case (kind)
                REG_LVL:  regs_d.lvl[psel*PORT_W +: PORT_W]    = wdata;
                REG_PULL: regs_d.pull_n[psel*PORT_W +: PORT_W] = wdata;
                REG_IEN:  regs_d.ien[psel*PORT_W +: PORT_W]    = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.lvl    <= '1;
            regs_q.pull_n <= '0;
            regs_q.ien    <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (kind)
                REG_LVL:  rdata = pin_sync[psel*PORT_W +: PORT_W];
                REG_PULL: rdata = regs_q.pull_n[psel*PORT_W +: PORT_W];
                REG_IEN:  rdata = regs_q.ien[psel*PORT_W +: PORT_W];
                default:  rdata = '0;
            endcase
        end
    end

    assign lvl    = regs_q.lvl;
    assign pull_n = regs_q.pull_n;
    assign ien    = regs_q.ien;

    // R8
    unmapped_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && kind == REG_NONE) |=> $stable(regs_q));

    // R8
    unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && kind == REG_NONE) |-> (rdata == '0));

    // R7
    idle_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> (rdata == '0));
endmodule

// File: rtl/qbio_pad_ctrl.sv
module qbio_pad_ctrl #(
    parameter int NLINES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] lvl,
    input  logic [NLINES-1:0] pull_n,
    input  logic              suspend,
    output logic [NLINES-1:0] drive_low,
    output logic [NLINES-1:0] pull_en,
    output logic [NLINES-1:0] hiz,
    output logic [NLINES-1:0] sink_en
);
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        always_comb begin
            drive_low[i] = ~lvl[i];
            pull_en[i]   = lvl[i] & ~pull_n[i];
            hiz[i]       = lvl[i] & pull_n[i];
            sink_en[i]   = ~lvl[i] & ~suspend;
        end
    end

    // R10
    sink_off_in_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |-> (sink_en == '0));

    // R10
    sink_follows_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !suspend |-> (sink_en == drive_low));
endmodule

// File: rtl/qbio_edge_irq.sv
module qbio_edge_irq #(
    parameter int NUM_PORTS = 2,
    parameter int PORT_W    = 8,
    localparam int NLINES   = NUM_PORTS * PORT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NLINES-1:0]    level,
    input  logic [NLINES-1:0]    ien,
    output logic [NUM_PORTS-1:0] irq
);
    typedef struct packed {
        logic [NLINES-1:0]    prev;
        logic [NUM_PORTS-1:0] irq;
    } st_t;

    st_t st_d, st_q;
    logic [NLINES-1:0] fall;

    always_comb begin
        fall      = st_q.prev & ~level & ien;
        st_d.prev = level;
        for (int p = 0; p < NUM_PORTS; p++) begin
            st_d.irq[p] = |fall[p*PORT_W +: PORT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= '1;
            st_q.irq  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        // R9
        irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[p] |=> !irq[p]);
        // R9
        irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[p] |-> $past(|ien[p*PORT_W +: PORT_W]));
    end
endmodule

// File: rtl/qbio_port_ctrl.sv
module qbio_port_ctrl #(
    parameter int NUM_PORTS   = 2,
    parameter int PORT_W      = 8,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int LVL_BASE    = 0,
    parameter int PULL_BASE   = 4,
    parameter int IEN_BASE    = 6,
    localparam int NLINES     = NUM_PORTS * PORT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic                 io_wr,
    input  logic [PORT_W-1:0]    io_wdata,
    input  logic                 io_rd,
    output logic [PORT_W-1:0]    io_rdata,
    input  logic [NLINES-1:0]    pin_in,
    input  logic                 suspend,
    output logic [NLINES-1:0]    pad_drive_low,
    output logic [NLINES-1:0]    pad_pull_en,
    output logic [NLINES-1:0]    pad_hiz,
    output logic [NLINES-1:0]    pad_sink_en,
    output logic [NUM_PORTS-1:0] irq_req
);
    logic [NLINES-1:0] pin_sync, lvl, pull_n, ien;

    qbio_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
    );

    qbio_regfile #(
        .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W),
        .LVL_BASE(LVL_BASE), .PULL_BASE(PULL_BASE), .IEN_BASE(IEN_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(io_addr), .wr(io_wr), .wdata(io_wdata),
        .rd(io_rd), .rdata(io_rdata), .pin_sync(pin_sync),
        .lvl(lvl), .pull_n(pull_n), .ien(ien)
    );

    qbio_pad_ctrl #(.NLINES(NLINES)) u_pads (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .pull_n(pull_n), .suspend(suspend),
        .drive_low(pad_drive_low), .pull_en(pad_pull_en), .hiz(pad_hiz),
        .sink_en(pad_sink_en)
    );

    qbio_edge_irq #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .level(pin_sync), .ien(ien), .irq(irq_req)
    );

    // R2 R3 R4: exactly one pad mode per line
    for (genvar i = 0; i < NLINES; i++) begin : g_mode_chk
        pad_mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot({pad_drive_low[i], pad_pull_en[i], pad_hiz[i]}));
    end

    // R5
    lvl_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == ADDR_W'(LVL_BASE))
        |=> (pad_drive_low[PORT_W-1:0] == ~$past(io_wdata)));
endmodule

// File: tb/qbio_port_ctrl_tb.sv
module qbio_port_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  io_addr = '0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic [15:0] pin_in = 16'hFFFF;
    logic        suspend = 1'b0;
    logic [15:0] pad_drive_low, pad_pull_en, pad_hiz, pad_sink_en;
    logic [1:0]  irq_req;

    int total = 0;
    int bad   = 0;
    logic [15:0] m_lvl  = 16'hFFFF;
    logic [15:0] m_pull = 16'h0000;

    always #5 clk = ~clk;

    qbio_port_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rd(io_rd), .io_rdata(io_rdata),
        .pin_in(pin_in), .suspend(suspend), .pad_drive_low(pad_drive_low),
        .pad_pull_en(pad_pull_en), .pad_hiz(pad_hiz), .pad_sink_en(pad_sink_en),
        .irq_req(irq_req)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        if (a == 8'h00) m_lvl[7:0]   = d;
        if (a == 8'h01) m_lvl[15:8]  = d;
        if (a == 8'h04) m_pull[7:0]  = d;
        if (a == 8'h05) m_pull[15:8] = d;
    endtask

    task automatic io_read(input logic [7:0] a, output logic [7:0] d);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic check_pads(input string req);
        chk({req, " drive_low"}, pad_drive_low, ~m_lvl);
        chk({req, " pull_en"},   pad_pull_en,   m_lvl & ~m_pull);
        chk({req, " hiz"},       pad_hiz,       m_lvl & m_pull);
        chk({req, " sink_en"},   pad_sink_en,   suspend ? 16'h0 : ~m_lvl);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 pull_en", pad_pull_en, 16'hFFFF);
        chk("R1 drive_low", pad_drive_low, 16'h0000);
        chk("R1 hiz", pad_hiz, 16'h0000);
        chk("R1 irq", {14'h0, irq_req}, 16'h0);
        io_read(8'h05, d); chk("R1 pull reg p1", {8'h0, d}, 16'h0000);
        io_read(8'h06, d); chk("R1 ien p0", {8'h0, d}, 16'h0000);
    endtask

    task automatic t_modes;
        io_write(8'h04, 8'hCC);
        io_write(8'h00, 8'hAA);
        check_pads("R2 R3 R4 port0 mix");
        chk("R2 low despite pull bit", {15'h0, pad_drive_low[2]}, 16'h1);
        chk("R4 hiz line3", {15'h0, pad_hiz[3]}, 16'h1);
        chk("R3 pull line1", {15'h0, pad_pull_en[1]}, 16'h1);
    endtask

    task automatic t_port1_map;
        io_write(8'h05, 8'h0F);
        io_write(8'h01, 8'h5A);
        check_pads("R5 port1 map");
        chk("R5 port0 untouched", pad_drive_low[7:0], 16'h0055);
    endtask

    task automatic t_read_pins;
        logic [7:0] d;
        pin_in = 16'h3C_96;
        @(negedge clk);
        io_read(8'h00, d); chk("R6 one edge old", {8'h0, d}, 16'h00FF);
        @(negedge clk);
        io_read(8'h00, d); chk("R6 port0 pins", {8'h0, d}, 16'h0096);
        io_read(8'h01, d); chk("R6 port1 pins", {8'h0, d}, 16'h003C);
        pin_in = 16'hFFFF;
        @(negedge clk); @(negedge clk);
        io_read(8'h00, d); chk("R6 not register", {8'h0, d}, 16'h00FF);
    endtask

    task automatic t_reg_read;
        logic [7:0] d;
        io_write(8'h07, 8'h81);
        io_read(8'h04, d); chk("R7 pull p0", {8'h0, d}, 16'h00CC);
        io_read(8'h07, d); chk("R7 ien p1", {8'h0, d}, 16'h0081);
        io_addr = 8'h04; #1;
        chk("R7 idle rdata", {8'h0, io_rdata}, 16'h0);
        io_write(8'h07, 8'h00);
    endtask

    task automatic t_unmapped;
        logic [7:0] d;
        io_write(8'h02, 8'h00);
        io_write(8'h03, 8'h00);
        io_write(8'h08, 8'h00);
        io_write(8'h0C, 8'hFF);
        check_pads("R8 writes ignored");
        io_read(8'h04, d); chk("R8 pull kept", {8'h0, d}, 16'h00CC);
        io_read(8'h06, d); chk("R8 ien kept", {8'h0, d}, 16'h0000);
        io_read(8'h02, d); chk("R8 read 0x02", {8'h0, d}, 16'h0);
        io_read(8'h0E, d); chk("R8 read 0x0E", {8'h0, d}, 16'h0);
    endtask

    task automatic t_irq;
        int hits;
        io_write(8'h06, 8'h08);
        pin_in[3] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 pulse high", {14'h0, irq_req}, 16'h1);
        @(negedge clk);
        chk("R9 pulse one cycle", {14'h0, irq_req}, 16'h0);
        hits = 0;
        pin_in[3] = 1'b1;
        for (int c = 0; c < 5; c++) begin @(negedge clk); if (irq_req != 0) hits++; end
        chk("R9 rising no irq", 16'(hits), 16'h0);
        pin_in[4] = 1'b0;
        for (int c = 0; c < 5; c++) begin @(negedge clk); if (irq_req != 0) hits++; end
        chk("R9 disabled no irq", 16'(hits), 16'h0);
        pin_in[4] = 1'b1;
        io_write(8'h07, 8'h40);
        repeat (3) @(negedge clk);
        pin_in[14] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 port1 pulse", {14'h0, irq_req}, 16'h2);
        @(negedge clk);
        chk("R9 port1 one cycle", {14'h0, irq_req}, 16'h0);
        pin_in[14] = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_suspend;
        suspend = 1'b1;
        #1 check_pads("R10 suspended");
        chk("R10 sink zero", pad_sink_en, 16'h0);
        suspend = 1'b0;
        #1 check_pads("R10 resumed");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_port1_map();
        t_read_pins();
        t_reg_read();
        t_unmapped();
        t_irq();
        t_suspend();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule